// File: doc/BRIEF.md
# Supply Power-Up Sequencing and Fault Timer

This block is the digital control core of a four-channel supply tracker. It takes comparator flags from the analog front end: one above-threshold flag for each monitored input, a supply-valid flag, the enable pin, a tracking-enable flag, a ramp-complete flag and a tracking-error flag. From these it decides when the tracked outputs may begin to ramp. It counts a coded gate delay before each ramp. It then supervises the power-up and power-down phases with a selectable fault window.

Outputs tell the analog loops what to do. `ramp_en` drives the up-ramp. `ramp_dn` drives the controlled power-down. `full_on` fully enhances the pass devices once power-up is complete. `fault_n` is the active-low fault line. It behaves like an open-drain pin. The surrounding logic wires it as a wired-OR with other devices and feeds the resolved level back in on `fault_sense_n`. A low level from any device then forces every device into shutdown. All durations are counted in units of `TICK_CYC` clock cycles, so a bench can shrink the time scale.

Top module: `supply_seq_core`

## Requirements
- R1: A power-up may start only when all four `in_ok` bits, `supply_ok`, `enable` and `trk_en` are high and `fault_sense_n` is high. While any of these is missing the block stays idle, with outputs {ramp_en,ramp_dn,full_on,fault_n} = 0001.
- R2: Once the start conditions hold at a clock edge, a gate delay of L units follows, and `ramp_en` rises at the edge L units later. The delay is set by `gate_code`: 0→1, 1→500, 2→1000, 3→2000, 4→4000, 5→8000, 6→16000, 7→64000. One unit is TICK_CYC clocks and stands for 25 µs.
- R3: If any start condition is lost during the gate delay, the block returns to idle at the next edge, and no ramp follows.
- R4: `ramp_done` high during the up-ramp moves the block to the on state at the next edge: `full_on`=1 and `ramp_en`=0.
- R5: The up-ramp is watched by a window of F units set by `fup_code` (0→1000, 1→2000, 2→4000, 3→8000). If the ramp has not completed F units after it began, `fault_n` goes low at that edge.
- R6: `trk_err` high during the up-ramp or the down-ramp sends the block to the fault state at the next edge. This takes priority over `ramp_done`.
- R7: `enable` low during the up-ramp or the on state starts a controlled power-down at the next edge (`ramp_dn`=1).
- R8: During the power-down, `ramp_done` returns the block to idle at the next edge. If the down-ramp takes longer than the window set by `fdn_code` (same mapping as R5), the block goes to fault instead.
- R9: `fault_sense_n` low while the block is active (gate delay, ramping, on) forces the fault state at the next edge. The block then drives `fault_n` low itself, so the shared line stays low.
- R10: The fault state is left only by reset or by a high-to-low transition of `enable`. A steadily low or steadily high `enable` keeps it.
- R11: At most one of `ramp_en`, `ramp_dn` and `full_on` is high at a time, and none is high while `fault_n` is low. Outputs are decoded from state and change one edge after the input that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ok | input | NCH | Per-channel input above its threshold |
| supply_ok | input | 1 | At least one supply is valid |
| enable | input | 1 | Enable pin; low requests power-down |
| trk_en | input | 1 | Tracking-enable flag |
| ramp_done | input | 1 | Ramp has reached its target in the current direction |
| trk_err | input | 1 | Tracking deviation beyond tolerance |
| gate_code | input | 3 | Gate-delay selection |
| fup_code | input | 2 | Power-up fault window selection |
| fdn_code | input | 2 | Power-down fault window selection |
| fault_sense_n | input | 1 | Resolved level of the shared fault line |
| ramp_en | output | 1 | Up-ramp loop active |
| ramp_dn | output | 1 | Down-ramp loop active |
| full_on | output | 1 | Pass devices fully enhanced |
| fault_n | output | 1 | Active-low fault drive (0 pulls the shared line low) |

## Verification
The bench hits the gate delay and both fault windows exactly one cycle before and at their expiry. An off-by-one timer would show a premature or late edge, and a wrong code decode would move the edge by thousands of cycles. It withdraws each start condition one at a time. This catches a design that ignores one flag, or that keeps ramping when a flag drops mid-delay. It also holds the fault line low from outside and then releases it. A design that does not latch its own drive would clear the shutdown. It applies `trk_err` together with `ramp_done`, which exposes a wrong priority. It leaves `enable` low after a power-down timeout, which exposes an exit on level rather than on a falling transition.

// File: rtl/supply_seq_core.sv
module supply_seq_core #(
  parameter int NCH      = 4,
  parameter int TICK_CYC = 6250,
  parameter int CNT_W    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] in_ok,
  input  logic           supply_ok,
  input  logic           enable,
  input  logic           trk_en,
  input  logic           ramp_done,
  input  logic           trk_err,
  input  logic [2:0]     gate_code,
  input  logic [1:0]     fup_code,
  input  logic [1:0]     fdn_code,
  input  logic           fault_sense_n,
  output logic           ramp_en,
  output logic           ramp_dn,
  output logic           full_on,
  output logic           fault_n
);
  localparam int PRE_W = $clog2(TICK_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_GATE, S_RUP, S_ON, S_RDN, S_FLT} st_t;

  st_t              st, st_nx;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, lim;
  logic             en_q;

  function automatic logic [CNT_W-1:0] gate_units(input logic [2:0] c);
    case (c)
      3'd0:    return CNT_W'(1);
      3'd7:    return CNT_W'(64000);
      default: return CNT_W'(500) << (c - 3'd1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] flt_units(input logic [1:0] c);
    return CNT_W'(1000) << c;
  endfunction

  wire start_ok = (&in_ok) & supply_ok & enable & trk_en & fault_sense_n;
  wire ext_flt  = !fault_sense_n;
  wire timed    = (st == S_GATE) || (st == S_RUP) || (st == S_RDN);
  wire tick     = timed && (pre == PRE_W'(TICK_CYC - 1));
  wire expire   = tick && (cnt == lim - CNT_W'(1));
  wire en_fall  = en_q && !enable;

  always_comb begin
    case (st)
      S_GATE:  lim = gate_units(gate_code);
      S_RUP:   lim = flt_units(fup_code);
      S_RDN:   lim = flt_units(fdn_code);
      default: lim = CNT_W'(1);
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (start_ok) st_nx = S_GATE;
      S_GATE: begin
        if (ext_flt)        st_nx = S_FLT;
        else if (!start_ok) st_nx = S_IDLE;
        else if (expire)    st_nx = S_RUP;
      end
      S_RUP: begin
        if (ext_flt || trk_err) st_nx = S_FLT;
        else if (!enable)       st_nx = S_RDN;
        else if (ramp_done)     st_nx = S_ON;
        else if (expire)        st_nx = S_FLT;
      end
      S_ON: begin
        if (ext_flt)      st_nx = S_FLT;
        else if (!enable) st_nx = S_RDN;
      end
      S_RDN: begin
        if (ext_flt || trk_err) st_nx = S_FLT;
        else if (ramp_done)     st_nx = S_IDLE;
        else if (expire)        st_nx = S_FLT;
      end
      S_FLT: if (en_fall) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pre  <= '0;
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      st   <= st_nx;
      en_q <= enable;
      if (!timed || st_nx != st) begin
        pre <= '0;
        cnt <= '0;
      end else if (tick) begin
        pre <= '0;
        cnt <= cnt + CNT_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  assign ramp_en = (st == S_RUP);
  assign ramp_dn = (st == S_RDN);
  assign full_on = (st == S_ON);
  assign fault_n = (st != S_FLT);
endmodule

// File: rtl/supply_seq_core_chk.sv
module supply_seq_core_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] in_ok,
  input logic           supply_ok,
  input logic           enable,
  input logic           trk_en,
  input logic           ramp_done,
  input logic           trk_err,
  input logic           fault_sense_n,
  input logic           ramp_en,
  input logic           ramp_dn,
  input logic           full_on,
  input logic           fault_n
);
  assert_rise_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> $past((&in_ok) && supply_ok && enable && trk_en && fault_sense_n));

  assert_done_to_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_on) |-> $past(ramp_en && ramp_done));

  assert_trk_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ramp_en || ramp_dn) && trk_err) |=> !fault_n);

  assert_pdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ramp_en || full_on) && !enable && fault_sense_n && !trk_err) |=> ramp_dn);

  assert_ext_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_sense_n && (ramp_en || ramp_dn || full_on)) |=> !fault_n);

  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && enable) |=> !fault_n);

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramp_en, ramp_dn, full_on, !fault_n}));
endmodule

bind supply_seq_core supply_seq_core_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ok(in_ok), .supply_ok(supply_ok),
  .enable(enable), .trk_en(trk_en), .ramp_done(ramp_done), .trk_err(trk_err),
  .fault_sense_n(fault_sense_n), .ramp_en(ramp_en), .ramp_dn(ramp_dn),
  .full_on(full_on), .fault_n(fault_n)
);

// File: tb/tb_supply_seq_core.sv
module tb_supply_seq_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] in_ok = '0;
  logic       supply_ok = 0, enable = 0, trk_en = 0, ramp_done = 0, trk_err = 0;
  logic [2:0] gate_code = '0;
  logic [1:0] fup_code = '0, fdn_code = '0;
  logic       ext_n = 1'b1;
  logic       ramp_en, ramp_dn, full_on, fault_n;
  wire        line_n = fault_n & ext_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [3:0] O_IDLE = 4'b0001, O_RUP = 4'b1001, O_RDN = 4'b0101,
                         O_ON = 4'b0011, O_FLT = 4'b0000;

  supply_seq_core #(.NCH(4), .TICK_CYC(1), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .in_ok(in_ok), .supply_ok(supply_ok),
    .enable(enable), .trk_en(trk_en), .ramp_done(ramp_done), .trk_err(trk_err),
    .gate_code(gate_code), .fup_code(fup_code), .fdn_code(fdn_code),
    .fault_sense_n(line_n), .ramp_en(ramp_en), .ramp_dn(ramp_dn),
    .full_on(full_on), .fault_n(fault_n)
  );

  always #2 clk = ~clk;

  function automatic int gate_u(input logic [2:0] c);
    case (c)
      3'd0: return 1;     3'd1: return 500;   3'd2: return 1000;  3'd3: return 2000;
      3'd4: return 4000;  3'd5: return 8000;  3'd6: return 16000; default: return 64000;
    endcase
  endfunction

  function automatic int flt_u(input logic [1:0] c);
    case (c)
      2'd0: return 1000; 2'd1: return 2000; 2'd2: return 4000; default: return 8000;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ramp_en, ramp_dn, full_on, fault_n};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_ok = '0; supply_ok = 0; enable = 0; trk_en = 0;
    ramp_done = 0; trk_err = 0; ext_n = 1;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic all_on();
    in_ok = 4'hF; supply_ok = 1; enable = 1; trk_en = 1;
  endtask

  task automatic power_up(input logic [2:0] g, input string req);
    int l;
    l = gate_u(g);
    gate_code = g;
    all_on();
    step(l);
    chk(req, O_IDLE);
    step(1);
    chk(req, O_RUP);
  endtask

  task automatic reach_on(input logic [2:0] g);
    power_up(g, "R2");
    ramp_done = 1;
    step(1);
    chk("R4", O_ON);
    ramp_done = 0;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    step(1);
    chk("R11 reset", O_IDLE);
    do_reset();
    chk("R1 after reset", O_IDLE);

    // R1: each missing condition blocks the start
    gate_code = 3'd0;
    for (int k = 0; k < 8; k++) begin
      do_reset();
      all_on();
      case (k)
        0, 1, 2, 3: in_ok[k] = 1'b0;
        4: supply_ok = 0;
        5: enable = 0;
        6: trk_en = 0;
        default: ext_n = 0;
      endcase
      step(6);
      chk("R1 missing condition", O_IDLE);
      all_on(); ext_n = 1;
      step(2);
      chk("R1 start after restore", O_RUP);
    end

    // R2: gate-delay decode at codes 3..7
    for (int g = 3; g < 8; g++) begin
      do_reset();
      power_up(3'(g), "R2 gate delay");
    end

    // R3: condition lost mid-delay
    do_reset();
    gate_code = 3'd3; all_on();
    step(10);
    trk_en = 0;
    step(1);
    chk("R3 abort", O_IDLE);
    step(2100);
    chk("R3 no ramp after abort", O_IDLE);

    // R5: up window codes 2 and 3
    for (int f = 2; f < 4; f++) begin
      do_reset();
      fup_code = 2'(f);
      power_up(3'd0, "R2");
      step(flt_u(2'(f)) - 1);
      chk("R5 before window", O_RUP);
      step(1);
      chk("R5 window expiry", O_FLT);
      step(3);
      chk("R10 hold with enable high", O_FLT);
      enable = 0;
      step(1);
      chk("R10 clear on enable fall", O_IDLE);
    end

    // R6: trk_err beats ramp_done
    do_reset();
    power_up(3'd0, "R2");
    step(5);
    ramp_done = 1; trk_err = 1;
    step(1);
    chk("R6 priority", O_FLT);
    ramp_done = 0; trk_err = 0;

    // R8/R10: down window code 3, enable stays low
    do_reset();
    fdn_code = 2'd3; fup_code = 2'd0;
    reach_on(3'd0);
    enable = 0;
    step(1);
    chk("R7 power-down", O_RDN);
    step(flt_u(2'd3) - 1);
    chk("R8 before down window", O_RDN);
    step(1);
    chk("R8 down window expiry", O_FLT);
    step(4);
    chk("R10 level low keeps fault", O_FLT);
    enable = 1;
    step(1);
    chk("R10 enable high keeps fault", O_FLT);
    enable = 0;
    step(1);
    chk("R10 enable fall clears", O_IDLE);

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      int kind, g, fu, fd, d;
      kind = $urandom_range(0, 4);
      g = $urandom_range(0, 2);
      fu = $urandom_range(0, 1);
      fd = $urandom_range(0, 1);
      do_reset();
      fup_code = 2'(fu); fdn_code = 2'(fd);
      d = $urandom_range(0, flt_u(2'(fu)) - 2);
      case (kind)
        0: begin
          power_up(3'(g), "R2");
          step(d);
          ramp_done = 1; step(1); chk("R4 random", O_ON); ramp_done = 0;
          step(7);
          enable = 0; step(1); chk("R7 random", O_RDN);
          step($urandom_range(0, flt_u(2'(fd)) - 2));
          ramp_done = 1; step(1); chk("R8 done to idle", O_IDLE); ramp_done = 0;
        end
        1: begin
          power_up(3'(g), "R2");
          step(flt_u(2'(fu)) - 1); chk("R5 random", O_RUP);
          step(1); chk("R5 random expiry", O_FLT);
          enable = 0; step(1); chk("R10 random", O_IDLE);
        end
        2: begin
          power_up(3'(g), "R2");
          step(d);
          trk_err = 1; step(1); chk("R6 random", O_FLT); trk_err = 0;
          enable = 0; step(1); chk("R10 random", O_IDLE);
        end
        3: begin
          reach_on(3'(g));
          step(d);
          ext_n = 0; step(1); chk("R9 external fault", O_FLT);
          ext_n = 1; step(3); chk("R9 own drive holds", O_FLT);
          enable = 0; step(1); chk("R10 random", O_IDLE);
        end
        default: begin
          reach_on(3'(g));
          enable = 0; step(1); chk("R7 random", O_RDN);
          step(3);
          trk_err = 1; step(1); chk("R6 down-ramp error", O_FLT); trk_err = 0;
        end
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule